// File: doc/BRIEF.md
# Banked Memory Address Generator

This block produces the 24-bit external address for every memory access of a small 8-bit processor. Each request carries a mode that picks where the 16-bit internal address comes from: the program counter for an instruction fetch, the 16-bit operand holder for direct accesses, pointer X or pointer Y for indirect accesses, or the stack pointer for stack accesses. An 8-bit bank register, loaded from the data bus, supplies the upper byte of the external address. With the bank held at zero, the machine behaves as a plain 16-bit one.

The program counter, the stack pointer, X, Y and the operand holder stay in the processor's register file and reach the block as plain inputs. The block does not write them. Instead, after an access it issues a one-cycle write strobe together with the new program counter or stack pointer value. If a second request is accepted while such a strobe is still being applied, the block uses the strobed value in place of the stale input.

Requests enter through a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The result is held in a single output register with its own valid/ready handshake. `req_ready` is high whenever that register is empty or is being drained in the same cycle (`addr_ready` high). While `addr_valid` is high and `addr_ready` is low, the address is held stable and no new request is accepted.

Top module: `bank_addr_gen`

## Requirements
- R1: While reset is active, and on the first cycle after it, `addr_valid`, `pc_we` and `sp_we` are low, `req_ready` is high, and the bank register is 0.
- R2: The external address is `{bank, internal}`, with the bank in bits 23:16. Right after reset the bank byte of every address is 0x00.
- R3: Mode 0 (fetch) addresses through the program counter. It pulses `pc_we` with `pc_next` equal to the counter plus one, wrapping 0xFFFF to 0x0000.
- R4: Mode 1 (direct) addresses through the operand holder input and raises no strobe.
- R5: Mode 2 (indirect) addresses through X when `req_ptr_sel` is 0 and through Y when it is 1, and raises no strobe.
- R6: Mode 3 (pop) addresses through the current stack pointer. It pulses `sp_we` with `sp_next` equal to the stack pointer minus one, wrapping 0x0000 to 0xFFFF with no fault.
- R7: Mode 4 (push) addresses the stack pointer plus one. It pulses `sp_we` with `sp_next` equal to that same address, wrapping 0xFFFF to 0x0000.
- R8: Mode 5 (stack read without adjust) addresses through the stack pointer and raises no strobe.
- R9: A `bank_ld` high on a rising edge captures `bank_din` into the bank register. A request accepted on that same edge still carries the previous bank.
- R10: An address appears on `addr_out` with `addr_valid` high in the cycle after its request is accepted. Any `pc_we`/`sp_we` for that access is high for exactly that one cycle.
- R11: While `addr_valid` is high and `addr_ready` is low, `addr_out` holds its value and `req_ready` is low.
- R12: A request accepted while `pc_we` (fetch) or `sp_we` (pop, push, stack read) is high uses `pc_next`/`sp_next` in place of `pc_in`/`sp_in`.
- R13: Reserved mode codes 6 and 7 address through the operand holder and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 3 | Address source code (0 fetch, 1 direct, 2 indirect, 3 pop, 4 push, 5 stack read) |
| req_ptr_sel | input | 1 | Indirect pointer choice: 0 = X, 1 = Y |
| pc_in | input | 16 | Program counter from the register file |
| sp_in | input | 16 | Stack pointer from the register file |
| x_in | input | 16 | Pointer X |
| y_in | input | 16 | Pointer Y |
| opnd_in | input | 16 | Operand holder value |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_din | input | 8 | Data bus byte for the bank register |
| addr_valid | output | 1 | Address register holds a result |
| addr_ready | input | 1 | Downstream takes the address |
| addr_out | output | 24 | External address |
| pc_we | output | 1 | Program counter write strobe |
| pc_next | output | 16 | New program counter value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_next | output | 16 | New stack pointer value |

## Verification
Every result of an accepted request (address, valid flag and strobes) is due exactly one rising edge after acceptance. A bank load takes effect on the same edge, but only for requests accepted after it. `req_ready` is combinational, so it is due in the same cycle as `addr_ready`. The bench drives inputs on the falling edge and checks `req_ready` a moment later in that same half cycle. It checks the registered outputs on the next falling edge, against a model that it advances once per rising edge. Forwarding is covered by the model: the bench's register file applies each strobe on the edge that ends the strobe cycle, exactly as the processor would.

// File: rtl/abg_pkg.sv
package abg_pkg;
  localparam int unsigned INT_AW  = 16;
  localparam int unsigned BANK_W  = 8;
  localparam int unsigned MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    M_FETCH  = 3'd0,
    M_DIRECT = 3'd1,
    M_INDIR  = 3'd2,
    M_POP    = 3'd3,
    M_PUSH   = 3'd4,
    M_PEEK   = 3'd5
  } mode_e;
endpackage

// File: rtl/abg_bank_reg.sv
module abg_bank_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (ld) q <= din;
  end
endmodule

// File: rtl/abg_fwd.sv
module abg_fwd #(
  parameter int unsigned W = 16
) (
  input  logic         pend,
  input  logic [W-1:0] pend_val,
  input  logic [W-1:0] reg_val,
  output logic [W-1:0] eff
);
  // A strobe still being applied means reg_val is one update behind.
  assign eff = pend ? pend_val : reg_val;
endmodule

// File: rtl/abg_src_sel.sv
module abg_src_sel
  import abg_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              ptr_sel,
  input  logic [AW-1:0]     pc_eff,
  input  logic [AW-1:0]     sp_eff,
  input  logic [AW-1:0]     x_val,
  input  logic [AW-1:0]     y_val,
  input  logic [AW-1:0]     opnd,
  output logic [AW-1:0]     int_addr,
  output logic              pc_upd,
  output logic [AW-1:0]     pc_new,
  output logic              sp_upd,
  output logic [AW-1:0]     sp_new
);
  logic [AW-1:0] sp_inc;
  logic [AW-1:0] sp_dec;

  assign sp_inc = sp_eff + AW'(1);
  assign sp_dec = sp_eff - AW'(1);
  assign pc_new = pc_eff + AW'(1);

  always_comb begin
    int_addr = opnd;
    pc_upd   = 1'b0;
    sp_upd   = 1'b0;
    sp_new   = sp_eff;
    case (mode)
      M_FETCH: begin
        int_addr = pc_eff;
        pc_upd   = 1'b1;
      end
      M_DIRECT: int_addr = opnd;
      M_INDIR:  int_addr = ptr_sel ? y_val : x_val;
      M_POP: begin
        int_addr = sp_eff;
        sp_upd   = 1'b1;
        sp_new   = sp_dec;
      end
      M_PUSH: begin
        int_addr = sp_inc;
        sp_upd   = 1'b1;
        sp_new   = sp_inc;
      end
      M_PEEK:  int_addr = sp_eff;
      default: int_addr = opnd;
    endcase
  end
endmodule

// File: rtl/abg_out_stage.sv
module abg_out_stage #(
  parameter int unsigned AW = 16,
  parameter int unsigned EW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [EW-1:0] in_addr,
  input  logic          in_pc_upd,
  input  logic [AW-1:0] in_pc_new,
  input  logic          in_sp_upd,
  input  logic [AW-1:0] in_sp_new,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [EW-1:0] out_addr,
  output logic          pc_we,
  output logic [AW-1:0] pc_next,
  output logic          sp_we,
  output logic [AW-1:0] sp_next
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      pc_we     <= 1'b0;
      pc_next   <= '0;
      sp_we     <= 1'b0;
      sp_next   <= '0;
    end else begin
      pc_we <= take && in_pc_upd;
      sp_we <= take && in_sp_upd;
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= in_addr;
        if (in_pc_upd) pc_next <= in_pc_new;
        if (in_sp_upd) sp_next <= in_sp_new;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import abg_pkg::*;
#(
  parameter int unsigned AW = INT_AW,
  parameter int unsigned BW = BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_ptr_sel,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     sp_in,
  input  logic [AW-1:0]     x_in,
  input  logic [AW-1:0]     y_in,
  input  logic [AW-1:0]     opnd_in,
  input  logic              bank_ld,
  input  logic [BW-1:0]     bank_din,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [AW+BW-1:0]  addr_out,
  output logic              pc_we,
  output logic [AW-1:0]     pc_next,
  output logic              sp_we,
  output logic [AW-1:0]     sp_next
);
  localparam int unsigned EW = AW + BW;

  logic [BW-1:0] bank_q;
  logic [AW-1:0] pc_eff, sp_eff, int_addr, pc_new, sp_new;
  logic          pc_upd, sp_upd;
  logic [EW-1:0] ext_addr;

  abg_bank_reg #(.W(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld(bank_ld), .din(bank_din), .q(bank_q)
  );

  abg_fwd #(.W(AW)) u_fwd_pc (
    .pend(pc_we), .pend_val(pc_next), .reg_val(pc_in), .eff(pc_eff)
  );

  abg_fwd #(.W(AW)) u_fwd_sp (
    .pend(sp_we), .pend_val(sp_next), .reg_val(sp_in), .eff(sp_eff)
  );

  abg_src_sel #(.AW(AW)) u_sel (
    .mode(req_mode), .ptr_sel(req_ptr_sel),
    .pc_eff(pc_eff), .sp_eff(sp_eff),
    .x_val(x_in), .y_val(y_in), .opnd(opnd_in),
    .int_addr(int_addr),
    .pc_upd(pc_upd), .pc_new(pc_new),
    .sp_upd(sp_upd), .sp_new(sp_new)
  );

  assign ext_addr = {bank_q, int_addr};

  abg_out_stage #(.AW(AW), .EW(EW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_addr(ext_addr),
    .in_pc_upd(pc_upd), .in_pc_new(pc_new),
    .in_sp_upd(sp_upd), .in_sp_new(sp_new),
    .out_valid(addr_valid), .out_ready(addr_ready), .out_addr(addr_out),
    .pc_we(pc_we), .pc_next(pc_next),
    .sp_we(sp_we), .sp_next(sp_next)
  );
endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [AW+BW-1:0]  addr_out,
  input logic              pc_we,
  input logic [AW-1:0]     pc_next,
  input logic              sp_we,
  input logic [AW-1:0]     sp_next,
  input logic [BW-1:0]     bank_q
);
  // R1: first cycle out of reset starts empty
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!addr_valid && !pc_we && !sp_we && bank_q == '0));

  // R11: stalled address holds and blocks new requests
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  a_r11_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |-> !req_ready);

  // R10: strobes only follow an accepted request
  a_r10_sp_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> $past(req_valid && req_ready));

  a_r10_pc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> $past(req_valid && req_ready));

  // R6 / R7: stack adjust is one step from the addressed location
  a_r6_r7_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (addr_out[AW-1:0] == sp_next || addr_out[AW-1:0] == sp_next + AW'(1)));

  // R3: fetch strobe is the fetched address plus one
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (pc_next == addr_out[AW-1:0] + AW'(1)));

  // R9: accepted request carries the bank held at acceptance
  a_r9_bank_at_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (addr_out[AW+BW-1:AW] == $past(bank_q)));

  // R10: at most one strobe per access
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_we, sp_we}));
endmodule

bind bank_addr_gen bank_addr_gen_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
  .pc_we(pc_we), .pc_next(pc_next), .sp_we(sp_we), .sp_next(sp_next),
  .bank_q(bank_q)
);

// File: tb/sim_bank_addr_gen.sv
module sim_bank_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = 3'd0;
  logic        req_ptr_sel = 1'b0;
  logic [15:0] pc_in, sp_in;
  logic [15:0] x_in = '0, y_in = '0, opnd_in = '0;
  logic        bank_ld = 1'b0;
  logic [7:0]  bank_din = '0;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [23:0] addr_out;
  logic        pc_we, sp_we;
  logic [15:0] pc_next, sp_next;

  // register file of the processor, written by the expected strobes
  logic [15:0] cpu_pc = 16'h0100;
  logic [15:0] cpu_sp = 16'h8000;
  assign pc_in = cpu_pc;
  assign sp_in = cpu_sp;

  int errors = 0;
  int checks = 0;

  // model state
  bit          m_valid = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_abank = '0;
  logic [7:0]  m_bank = '0;
  bit          m_pcwe = 0, m_spwe = 0;
  logic [15:0] m_pcnext = '0, m_spnext = '0;
  string       m_tag = "R4";

  always #4 clk = ~clk;

  bank_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_ptr_sel(req_ptr_sel),
    .pc_in(pc_in), .sp_in(sp_in), .x_in(x_in), .y_in(y_in), .opnd_in(opnd_in),
    .bank_ld(bank_ld), .bank_din(bank_din),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .pc_we(pc_we), .pc_next(pc_next), .sp_we(sp_we), .sp_next(sp_next)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [2:0] md, input bit sel,
      input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] x,
      input logic [15:0] y, input logic [15:0] op);
    case (md)
      3'd0: return pc;
      3'd2: return sel ? y : x;
      3'd3: return sp;
      3'd4: return sp + 16'd1;
      3'd5: return sp;
      default: return op;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] md);
    case (md)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R13";
    endcase
  endfunction

  // one cycle: check registered outputs, drive, check ready, advance model
  task automatic cyc(input bit v, input logic [2:0] md, input bit sel,
                     input bit rdy, input bit ld, input logic [7:0] din);
    bit acc, exp_rdy, fw;
    logic [15:0] pc_e, sp_e;
    bit n_valid, n_pcwe, n_spwe;
    logic [15:0] n_addr, n_pcnext, n_spnext, n_cpu_pc, n_cpu_sp;
    logic [7:0] n_abank, n_bank;
    string n_tag;

    chk("R10 addr_valid", 32'(addr_valid), 32'(m_valid));
    if (m_valid) begin
      chk({m_tag, " addr"}, 32'(addr_out[15:0]), 32'(m_addr));
      chk("R2/R9 bank byte", 32'(addr_out[23:16]), 32'(m_abank));
    end
    chk("R10 pc_we", 32'(pc_we), 32'(m_pcwe));
    chk("R10 sp_we", 32'(sp_we), 32'(m_spwe));
    if (m_pcwe) chk({m_tag, " pc_next"}, 32'(pc_next), 32'(m_pcnext));
    if (m_spwe) chk({m_tag, " sp_next"}, 32'(sp_next), 32'(m_spnext));

    req_valid   = v;
    req_mode    = md;
    req_ptr_sel = sel;
    addr_ready  = rdy;
    bank_ld     = ld;
    bank_din    = din;
    x_in        = 16'($urandom);
    y_in        = 16'($urandom);
    opnd_in     = 16'($urandom);
    #1;
    exp_rdy = !m_valid || rdy;
    chk("R11 req_ready", 32'(req_ready), 32'(exp_rdy));

    acc  = v && exp_rdy;
    pc_e = m_pcwe ? m_pcnext : cpu_pc;   // R12
    sp_e = m_spwe ? m_spnext : cpu_sp;   // R12
    fw   = (md == 3'd0 && m_pcwe) || ((md == 3'd3 || md == 3'd4 || md == 3'd5) && m_spwe);

    n_valid = m_valid; n_addr = m_addr; n_abank = m_abank; n_tag = m_tag;
    n_pcnext = m_pcnext; n_spnext = m_spnext;
    n_pcwe = acc && md == 3'd0;
    n_spwe = acc && (md == 3'd3 || md == 3'd4);
    if (acc) begin
      n_valid = 1;
      n_addr  = exp_addr(md, sel, pc_e, sp_e, x_in, y_in, opnd_in);
      n_abank = m_bank;                  // R9: old bank on a same-edge load
      n_tag   = fw ? "R12" : mode_tag(md);
      if (md == 3'd0) n_pcnext = pc_e + 16'd1;
      if (md == 3'd3) n_spnext = sp_e - 16'd1;
      if (md == 3'd4) n_spnext = sp_e + 16'd1;
    end else if (rdy) begin
      n_valid = 0;
    end
    n_bank   = ld ? din : m_bank;
    n_cpu_pc = m_pcwe ? m_pcnext : cpu_pc;
    n_cpu_sp = m_spwe ? m_spnext : cpu_sp;

    @(posedge clk);
    m_valid = n_valid; m_addr = n_addr; m_abank = n_abank; m_tag = n_tag;
    m_pcwe = n_pcwe; m_spwe = n_spwe; m_pcnext = n_pcnext; m_spnext = n_spnext;
    m_bank = n_bank; cpu_pc <= n_cpu_pc; cpu_sp <= n_cpu_sp;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240513));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while in reset
    chk("R1 addr_valid", 32'(addr_valid), 0);
    chk("R1 pc_we", 32'(pc_we), 0);
    chk("R1 sp_we", 32'(sp_we), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: fetch with bank 0 gives a zero bank byte; R9: same-edge load
    cyc(1, 3'd0, 0, 1, 1, 8'hA5);
    cyc(1, 3'd0, 0, 1, 0, 8'h00);        // R12 fetch forwarding
    cyc(1, 3'd1, 0, 1, 0, 8'h00);        // carries bank A5
    cyc(0, 3'd0, 0, 1, 1, 8'h00);
    cyc(0, 3'd0, 0, 1, 0, 8'h00);

    // R5: both pointers
    cyc(1, 3'd2, 0, 1, 0, 8'h00);
    cyc(1, 3'd2, 1, 1, 0, 8'h00);
    cyc(0, 3'd0, 0, 1, 0, 8'h00);

    // R6: pop wrap at 0x0000
    cpu_sp = 16'h0000;
    cyc(1, 3'd3, 0, 1, 0, 8'h00);
    cyc(0, 3'd0, 0, 1, 0, 8'h00);
    cyc(0, 3'd0, 0, 1, 0, 8'h00);
    // R7: push wrap at 0xFFFF
    cpu_sp = 16'hFFFF;
    cyc(1, 3'd4, 0, 1, 0, 8'h00);
    cyc(0, 3'd0, 0, 1, 0, 8'h00);
    cyc(0, 3'd0, 0, 1, 0, 8'h00);

    // R12: back-to-back stack traffic, R8 read without adjust
    cyc(1, 3'd4, 0, 1, 0, 8'h00);
    cyc(1, 3'd4, 0, 1, 0, 8'h00);
    cyc(1, 3'd3, 0, 1, 0, 8'h00);
    cyc(1, 3'd5, 0, 1, 0, 8'h00);
    cyc(1, 3'd3, 0, 1, 0, 8'h00);

    // R11: stall with a pending request
    cyc(1, 3'd1, 0, 0, 0, 8'h00);
    cyc(1, 3'd2, 0, 0, 0, 8'h00);
    cyc(1, 3'd2, 0, 0, 0, 8'h00);
    cyc(1, 3'd2, 1, 1, 0, 8'h00);
    // R13: reserved codes
    cyc(1, 3'd6, 0, 1, 0, 8'h00);
    cyc(1, 3'd7, 1, 1, 0, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] | r[1], 3'(r[4:2]), r[5], r[8:6] != 3'd0, r[13:9] == 5'd0, 8'(r[31:24]));
    end
    repeat (3) cyc(0, 3'd0, 0, 1, 0, 8'h00);

    summary();
    $finish;
  end
endmodule